// File: doc/BRIEF.md
# Byte-Enable Register Access Adapter

This block turns a single internal register request into the two-step access that a 16-bit external network-controller bus expects. That bus has two locations. One is a command location. The other is a data location. For each request, the adapter first writes a command word to the command location. The command word holds the register offset in its low bits and a nibble of byte-enable bits in its top four bits. The adapter then performs exactly one access at the data location.

On the request side a valid/ready handshake is used. Each request carries an offset, a size (byte or halfword), a direction and write data. Each bus phase holds a strobe until the external side acknowledges it. A byte write places its byte in the lane that the offset selects. A byte read returns the selected byte right-aligned. Completion is signalled by a one-cycle done pulse that carries the read data.

Top module: `regbus_be_bridge`

## Requirements
- R1: After reset, `req_ready` is 1, while `rsp_done` and `bus_strb` are 0.
- R2: An accepted request first raises `bus_strb` with `bus_cmd_sel`=1 and `bus_we`=1. The command word on `bus_wdata` carries the offset, zero-extended, in bits 11:0 and the byte enables in bits 15:12.
- R3: For a byte access, exactly one enable bit is set. It is bit 12 + offset[1:0]: offset 0 gives 0x1000, offset 1 gives 0x2000, offset 2 gives 0x4000 and offset 3 gives 0x8000.
- R4: For a halfword access, two enable bits are set. Bits 13:12 are set when offset[1] is 0, and bits 15:14 when offset[1] is 1. Offset[0] does not change the enables.
- R5: Each phase keeps `bus_strb`, `bus_cmd_sel` and `bus_wdata` steady until `bus_ack`. The cycle after the command phase is acknowledged, the data phase starts with `bus_cmd_sel`=0. Each request makes exactly these two phases.
- R6: A byte write drives `req_wdata[7:0]` onto data bits 15:8 when offset[0] is 1, and onto bits 7:0 otherwise. The other byte is zero and `req_wdata[15:8]` is ignored.
- R7: A byte read returns the bus word's bits 15:8 when offset[0] is 1, and bits 7:0 otherwise, in `rsp_rdata[7:0]`. `rsp_rdata[15:8]` is 0.
- R8: A halfword access passes the whole 16-bit word unchanged: `req_wdata` goes to the bus on a write, and the bus word comes back on `rsp_rdata` on a read.
- R9: `rsp_done` is high for exactly one cycle, the cycle after the data phase is acknowledged. `rsp_rdata` is valid in that cycle.
- R10: `req_ready` is 0 from acceptance until the cycle of `rsp_done`. Request inputs that change in that window do not affect the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Adapter idle, request taken on this edge |
| req_offset | input | OFFSET_W | Register offset |
| req_wide | input | 1 | 1 = halfword, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Aligned read data |
| bus_strb | output | 1 | Bus phase strobe |
| bus_cmd_sel | output | 1 | 1 = command location, 0 = data location |
| bus_we | output | 1 | Bus write enable |
| bus_wdata | output | 16 | Bus write word |
| bus_rdata | input | 16 | Bus read word |
| bus_ack | input | 1 | Phase acknowledge |

## Verification
The vector table walks a byte access through all four offset lanes, in both directions. This shows whether the enable nibble and the byte-lane steering follow offset[1:0] and offset[0] separately. Halfword accesses at both offset[1] values tell the paired enables apart from the single ones, and show that the full word is passed unshifted. A maximal offset shows that offset bits reach the command word without disturbing the enables. Write data with a non-zero upper byte, and read words whose two bytes differ, expose a wrong or unmasked lane. Changing acknowledge latency and request inputs that keep moving while the adapter is busy show that the phases hold their values and keep their order.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

    localparam int WORD_W = 16;
    localparam int LANES  = 4;
    localparam int OFS_W  = WORD_W - LANES;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CMD  = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    typedef struct packed {
        logic [OFS_W-1:0]  offset;
        logic              wide;
        logic              write;
        logic [WORD_W-1:0] wdata;
    } req_t;

    function automatic logic [WORD_W-1:0] place_wdata(input req_t r);
        if (r.wide)
            return r.wdata;
        else if (r.offset[0])
            return {r.wdata[7:0], 8'h00};
        else
            return {8'h00, r.wdata[7:0]};
    endfunction

    function automatic logic [WORD_W-1:0] align_rdata(input logic wide,
                                                      input logic odd,
                                                      input logic [WORD_W-1:0] w);
        if (wide)
            return w;
        else if (odd)
            return {8'h00, w[15:8]};
        else
            return {8'h00, w[7:0]};
    endfunction

endpackage

// File: rtl/regbus_cmd_gen.sv
module regbus_cmd_gen
    import regbus_pkg::*;
(
    input  req_t              req,
    output logic [WORD_W-1:0] cmd_word,
    output logic [WORD_W-1:0] data_word
);
    logic [LANES-1:0] lane_en;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [1:0] LANE = 2'(i);
        assign lane_en[i] = req.wide ? (req.offset[1] == LANE[1])
                                     : (req.offset[1:0] == LANE);
    end

    assign cmd_word  = {lane_en, req.offset};
    assign data_word = place_wdata(req);
endmodule

// File: rtl/regbus_rd_align.sv
module regbus_rd_align
    import regbus_pkg::*;
(
    input  req_t              req,
    input  logic [WORD_W-1:0] bus_word,
    output logic [WORD_W-1:0] aligned
);
    assign aligned = align_rdata(req.wide, req.offset[0], bus_word);
endmodule

// File: rtl/regbus_seq.sv
module regbus_seq
    import regbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  req_t              in_req,
    output logic              in_ready,
    input  logic              ack,
    input  logic [WORD_W-1:0] aligned_rd,
    output req_t              held_req,
    output phase_e            phase,
    output logic              done,
    output logic [WORD_W-1:0] rdata
);
    phase_e phase_q;
    req_t   req_q;

    assign in_ready = (phase_q == PH_IDLE);
    assign held_req = req_q;
    assign phase    = phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            req_q   <= '0;
            done    <= 1'b0;
            rdata   <= '0;
        end else begin
            done <= 1'b0;
            case (phase_q)
                PH_IDLE: if (in_valid) begin
                    req_q   <= in_req;
                    phase_q <= PH_CMD;
                end
                PH_CMD: if (ack) phase_q <= PH_DATA;
                PH_DATA: if (ack) begin
                    done    <= 1'b1;
                    rdata   <= aligned_rd;
                    phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/regbus_be_bridge.sv
module regbus_be_bridge
    import regbus_pkg::*;
#(
    parameter int OFFSET_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [OFFSET_W-1:0] req_offset,
    input  logic                req_wide,
    input  logic                req_write,
    input  logic [15:0]         req_wdata,
    output logic                rsp_done,
    output logic [15:0]         rsp_rdata,
    output logic                bus_strb,
    output logic                bus_cmd_sel,
    output logic                bus_we,
    output logic [15:0]         bus_wdata,
    input  logic [15:0]         bus_rdata,
    input  logic                bus_ack
);
    req_t              new_req;
    req_t              cur_req;
    phase_e            phase;
    logic [WORD_W-1:0] cmd_word;
    logic [WORD_W-1:0] data_word;
    logic [WORD_W-1:0] aligned;

    always_comb begin
        new_req        = '0;
        new_req.offset = OFS_W'(req_offset);
        new_req.wide   = req_wide;
        new_req.write  = req_write;
        new_req.wdata  = req_wdata;
    end

    regbus_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (req_valid),
        .in_req     (new_req),
        .in_ready   (req_ready),
        .ack        (bus_ack),
        .aligned_rd (aligned),
        .held_req   (cur_req),
        .phase      (phase),
        .done       (rsp_done),
        .rdata      (rsp_rdata)
    );

    regbus_cmd_gen u_cmd (
        .req       (cur_req),
        .cmd_word  (cmd_word),
        .data_word (data_word)
    );

    regbus_rd_align u_align (
        .req      (cur_req),
        .bus_word (bus_rdata),
        .aligned  (aligned)
    );

    assign bus_strb    = (phase != PH_IDLE);
    assign bus_cmd_sel = (phase == PH_CMD);
    assign bus_we      = (phase == PH_CMD) || (phase == PH_DATA && cur_req.write);
    assign bus_wdata   = (phase == PH_CMD)  ? cmd_word :
                         (phase == PH_DATA) ? data_word : '0;
endmodule

// File: rtl/regbus_be_bridge_chk.sv
module regbus_be_bridge_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_ready,
    input logic        rsp_done,
    input logic        bus_strb,
    input logic        bus_cmd_sel,
    input logic        bus_we,
    input logic [15:0] bus_wdata,
    input logic        bus_ack
);
    p_cmd_first_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_strb) |-> bus_cmd_sel && bus_we);

    p_be_count_r4: assert property (@(posedge clk) disable iff (rst)
        bus_strb && bus_cmd_sel |->
            ($countones(bus_wdata[15:12]) == 1 || $countones(bus_wdata[15:12]) == 2));

    p_phase_hold_r5: assert property (@(posedge clk) disable iff (rst)
        bus_strb && !bus_ack |=>
            bus_strb && $stable(bus_cmd_sel) && $stable(bus_wdata));

    p_cmd_then_data_r5: assert property (@(posedge clk) disable iff (rst)
        bus_strb && bus_cmd_sel && bus_ack |=> bus_strb && !bus_cmd_sel);

    p_done_after_ack_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> $past(bus_strb && !bus_cmd_sel && bus_ack));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (rst)
        bus_strb |-> !req_ready);
endmodule

bind regbus_be_bridge regbus_be_bridge_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_ready   (req_ready),
    .rsp_done    (rsp_done),
    .bus_strb    (bus_strb),
    .bus_cmd_sel (bus_cmd_sel),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_ack     (bus_ack)
);

// File: tb/test_regbus_be_bridge.sv
module test_regbus_be_bridge;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [11:0] req_offset = '0;
    logic        req_wide = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic        bus_strb;
    logic        bus_cmd_sel;
    logic        bus_we;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    regbus_be_bridge #(.OFFSET_W(12)) i_regbus_be_bridge (
        .clk, .rst, .req_valid, .req_ready, .req_offset, .req_wide,
        .req_write, .req_wdata, .rsp_done, .rsp_rdata, .bus_strb,
        .bus_cmd_sel, .bus_we, .bus_wdata, .bus_rdata, .bus_ack
    );

    typedef struct packed {
        logic [11:0] ofs;
        logic        wide;
        logic        wr;
        logic [15:0] wd;
        logic [15:0] brd;
        logic [15:0] ecmd;
        logic [15:0] eval;
        logic [1:0]  lat;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{12'h010, 1'b0, 1'b1, 16'hFFA5, 16'h0000, 16'h1010, 16'h00A5, 2'd0},
        '{12'h011, 1'b0, 1'b1, 16'h773C, 16'h0000, 16'h2011, 16'h3C00, 2'd1},
        '{12'h012, 1'b0, 1'b0, 16'h0000, 16'hBEEF, 16'h4012, 16'h00EF, 2'd2},
        '{12'h013, 1'b0, 1'b0, 16'h0000, 16'hBEEF, 16'h8013, 16'h00BE, 2'd0},
        '{12'h021, 1'b1, 1'b1, 16'h1234, 16'h0000, 16'h3021, 16'h1234, 2'd1},
        '{12'h022, 1'b1, 1'b0, 16'h0000, 16'hCAFE, 16'hC022, 16'hCAFE, 2'd2},
        '{12'hFFF, 1'b0, 1'b0, 16'h0000, 16'h5A00, 16'h8FFF, 16'h005A, 2'd1},
        '{12'h000, 1'b1, 1'b0, 16'h0000, 16'h0001, 16'h3000, 16'h0001, 2'd0}
    };

    task automatic chk(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    // Drives one request and acts as the bus target; all sampling on negedges.
    task automatic run(input vec_t v);
        @(negedge clk);
        req_valid  = 1'b1;
        req_offset = v.ofs;
        req_wide   = v.wide;
        req_write  = v.wr;
        req_wdata  = v.wd;
        @(negedge clk);
        // R10: inputs scrambled while busy must not reach the bus
        req_offset = ~v.ofs;
        req_wide   = ~v.wide;
        req_write  = ~v.wr;
        req_wdata  = ~v.wd;
        chk(req_ready == 1'b0, "R10 ready low when busy", 16'(req_ready), 16'h0);
        chk(bus_strb && bus_cmd_sel && bus_we, "R2 command phase first",
            {13'h0, bus_strb, bus_cmd_sel, bus_we}, 16'h0007);
        for (int k = 0; k < int'(v.lat); k++) begin
            @(negedge clk);
            chk(bus_strb && bus_cmd_sel && bus_wdata == v.ecmd, "R5 command held",
                bus_wdata, v.ecmd);
        end
        chk(bus_wdata == v.ecmd, v.wide ? "R4 command word" : "R3 command word",
            bus_wdata, v.ecmd);
        bus_ack = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0;
        chk(bus_strb && !bus_cmd_sel && bus_we == v.wr, "R5 data phase follows",
            {13'h0, bus_strb, bus_cmd_sel, bus_we}, {13'h0, 1'b1, 1'b0, v.wr});
        for (int k = 0; k < int'(v.lat); k++) begin
            @(negedge clk);
            chk(bus_strb && !bus_cmd_sel && !rsp_done, "R5 data held",
                {15'h0, bus_strb}, 16'h1);
        end
        if (v.wr)
            chk(bus_wdata == v.eval, v.wide ? "R8 halfword write" : "R6 byte write lane",
                bus_wdata, v.eval);
        bus_rdata = v.brd;
        bus_ack   = 1'b1;
        @(negedge clk);
        bus_ack   = 1'b0;
        bus_rdata = 16'hDEAD;
        req_valid = 1'b0;
        chk(rsp_done == 1'b1, "R9 done after data ack", 16'(rsp_done), 16'h1);
        chk(req_ready == 1'b1, "R10 ready with done", 16'(req_ready), 16'h1);
        if (!v.wr)
            chk(rsp_rdata == v.eval, v.wide ? "R8 halfword read" : "R7 byte read align",
                rsp_rdata, v.eval);
        @(negedge clk);
        chk(rsp_done == 1'b0 && bus_strb == 1'b0, "R9 done single pulse",
            {14'h0, rsp_done, bus_strb}, 16'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 reset ready", 16'(req_ready), 16'h1);
        chk(rsp_done == 1'b0 && bus_strb == 1'b0, "R1 reset idle",
            {14'h0, rsp_done, bus_strb}, 16'h0);

        for (int i = 0; i < NV; i++) run(VECS[i]);

        // R4 corner: odd offset with halfword read keeps pair at 15:14
        run('{12'h7A3, 1'b1, 1'b0, 16'h0000, 16'h8001, 16'hC7A3, 16'h8001, 2'd0});
        // R3 corner: byte write to lane 2, upper request byte ignored (R6)
        run('{12'h002, 1'b0, 1'b1, 16'hAB01, 16'h0000, 16'h4002, 16'h0001, 2'd2});

        // Reset mid-transaction returns to idle (R1)
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1 && bus_strb == 1'b0, "R1 reset during access",
            {14'h0, req_ready, bus_strb}, 16'h2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule